// File: doc/BRIEF.md
# Register-Controlled SPI Host Shift Engine

This block is an SPI host that software drives through six 32-bit registers on a simple memory-mapped bus. Software first sets a master enable. It then programs a clock divisor and places up to 32 outgoing bits in a transmit register. One write to the shift-control word starts the transfer. That same word selects one of three active-low chip selects, gives the bit count, and says whether the chip select is released when the transfer ends. If the chip select is kept, one device select can span several 32-bit chunks.

The engine runs SPI mode 0 only. SCK idles low. MOSI changes while SCK is low. MISO is sampled on each rising SCK edge and shifted into a receive register from the LSB side. When the engine is not driving the pins, a pin-override register sets their idle levels. Software polls the busy bit to detect completion.

Register map (byte offsets on `busAddr`):

| Offset | Register | Access |
|---|---|---|
| 0x00 | master enable | read/write |
| 0x04 | clock divisor | read/write |
| 0x08 | pin override | read/write |
| 0x10 | transmit data | read/write |
| 0x14 | shift control | read/write |
| 0x18 | receive data | read only |

Top module: `spi_shift_host`

## Requirements
- R1: After reset, csN is 3'b111 and sck and mosi are 0. Offset 0x00 reads 0, and once enabled, offset 0x08 reads 0x00070000.
- R2: While bit 0 of the master-enable register (offset 0x00) is clear, writes to every other offset are ignored and have no effect on the pins, and reads of those offsets return 0.
- R3: Writing shift control (offset 0x14) with bit 31 set starts a transfer. Bit 31 then reads 1 for exactly 2·n·(div+1) clock cycles, counted from the write edge, and reads 0 afterwards.
- R4: Bit 28+k of shift control selects chip select k (k = 0..2). csN[k] is driven low for the whole transfer.
- R5: If bit 26 (terminate) is set, the selected chip select returns to its pin-override level when the transfer ends. If bit 26 is clear, it stays low until a later transfer that ends with terminate set.
- R6: Bits 5:0 of shift control give the bit count n, from 1 to 32; a value of 0 or above 32 means 32. The low n bits of the transmit register (offset 0x10) go out MSB first.
- R7: Bits 5:0 of offset 0x04 hold div. Each SCK half period lasts div+1 clock cycles, and exactly n rising SCK edges occur per transfer.
- R8: MISO is sampled on each rising SCK edge and shifted in at bit 0. After the transfer, the receive register (offset 0x18) holds the n received bits with the last one in bit 0. The receive register is cleared when a transfer starts.
- R9: SCK is low whenever the engine is idle and at the end of every transfer. MOSI is stable across each rising edge.
- R10: When the engine is not driving the pins, the pin-override register (offset 0x08) drives them: bit 0 sets mosi, bit 8 sets sck, and bits 18:16 set the csN levels.
- R11: A write to shift control while bit 31 reads 1 is ignored. The fields, the chip select and the timing of the running transfer are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| csN | output | 3 | Active-low chip selects |

## Verification
A register write takes effect at the clock edge where it is sampled. Reads are combinational, so the bench samples busRdata at the falling clock edge, one nanosecond after it sets the address. The busy bit is checked at two points: one falling edge before the 2·n·(div+1)-th edge after the start write, where it must still read 1, and the falling edge just after it, where it must read 0. This pins the transfer length to the exact cycle. Chip-select levels are checked at the transfer midpoint and after the end. MOSI bits and rising-edge counts are collected on SCK's own rising edges, and the bench model of the device updates MISO only on falling SCK edges, so neither depends on the ordering of clock-edge events.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  // Register byte offsets
  localparam int OFS_FUNC = 'h00;
  localparam int OFS_DIV  = 'h04;
  localparam int OFS_PIN  = 'h08;
  localparam int OFS_TX   = 'h10;
  localparam int OFS_SC   = 'h14;
  localparam int OFS_RX   = 'h18;

  // Shift-control field positions
  localparam int SC_START = 31;
  localparam int SC_CS_LO = 28;
  localparam int SC_TERM  = 26;

  // Pin-override field positions
  localparam int PIN_MOSI  = 0;
  localparam int PIN_SCK   = 8;
  localparam int PIN_CS_LO = 16;

  typedef struct packed {
    logic load;   // begin a transfer
    logic rise;   // SCK rising edge: sample MISO
    logic fall;   // SCK falling edge: advance MOSI
  } shiftStrobe_t;
endpackage

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rxData,
  output shiftStrobe_t      strobe,
  output logic              busy,
  output logic [CNT_W-1:0]  loadCount,
  output logic [DATA_W-1:0] txData,
  output logic [NUM_CS-1:0] pinCs,
  output logic              pinSck,
  output logic              pinMosi,
  output logic [NUM_CS-1:0] activeCs
);
  logic              funcOn;
  logic [DIV_W-1:0]  divReg;
  logic [DATA_W-1:0] txReg;
  logic [NUM_CS-1:0] pinCsReg, csSelReg, activeCsReg;
  logic              pinSckReg, pinMosiReg, termReg;
  logic [CNT_W-1:0]  cntField, bitsLeft;
  logic [DIV_W-1:0]  divCnt;
  logic              phaseHigh, busyReg;

  logic              wrAny, regWr, scWr, start, tick, lastFall;
  logic [CNT_W-1:0]  wrCount, effCount;
  logic              unusedWdata;

  assign unusedWdata = ^{busWdata[SC_TERM+1], busWdata[SC_TERM-1:CNT_W]};

  assign wrAny    = busSel & busWrite;
  assign regWr    = wrAny & funcOn;
  assign scWr     = regWr & (busAddr == ADDR_W'(OFS_SC)) & ~busyReg;
  assign start    = scWr & busWdata[SC_START];
  assign wrCount  = busWdata[CNT_W-1:0];
  assign effCount = ((wrCount == '0) || (wrCount > CNT_W'(DATA_W))) ? CNT_W'(DATA_W) : wrCount;
  assign tick     = busyReg & (divCnt >= divReg);
  assign lastFall = tick & phaseHigh & (bitsLeft == CNT_W'(1));

  assign strobe.load = start;
  assign strobe.rise = tick & ~phaseHigh;
  assign strobe.fall = tick & phaseHigh;

  // Register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcOn     <= 1'b0;
      divReg     <= '0;
      txReg      <= '0;
      pinCsReg   <= '1;
      pinSckReg  <= 1'b0;
      pinMosiReg <= 1'b0;
      csSelReg   <= '0;
      termReg    <= 1'b0;
      cntField   <= '0;
    end else begin
      if (wrAny && busAddr == ADDR_W'(OFS_FUNC)) funcOn <= busWdata[0];
      if (regWr && busAddr == ADDR_W'(OFS_DIV))  divReg <= busWdata[DIV_W-1:0];
      if (regWr && busAddr == ADDR_W'(OFS_TX))   txReg  <= busWdata;
      if (regWr && busAddr == ADDR_W'(OFS_PIN)) begin
        pinMosiReg <= busWdata[PIN_MOSI];
        pinSckReg  <= busWdata[PIN_SCK];
        pinCsReg   <= busWdata[PIN_CS_LO +: NUM_CS];
      end
      if (scWr) begin
        csSelReg <= busWdata[SC_CS_LO +: NUM_CS];
        termReg  <= busWdata[SC_TERM];
        cntField <= wrCount;
      end
    end
  end

  // Transfer sequencer: half-period divider, bit counter, chip-select hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg     <= 1'b0;
      divCnt      <= '0;
      phaseHigh   <= 1'b0;
      bitsLeft    <= '0;
      activeCsReg <= '0;
    end else if (start) begin
      busyReg     <= 1'b1;
      divCnt      <= '0;
      phaseHigh   <= 1'b0;
      bitsLeft    <= effCount;
      activeCsReg <= busWdata[SC_CS_LO +: NUM_CS];
    end else if (tick) begin
      divCnt    <= '0;
      phaseHigh <= ~phaseHigh;
      if (phaseHigh) bitsLeft <= bitsLeft - 1'b1;
      if (lastFall) begin
        busyReg <= 1'b0;
        if (termReg) activeCsReg <= '0;
      end
    end else if (busyReg) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Combinational read mux
  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_FUNC)) begin
      busRdata[0] = funcOn;
    end else if (funcOn) begin
      case (busAddr)
        ADDR_W'(OFS_DIV): busRdata[DIV_W-1:0] = divReg;
        ADDR_W'(OFS_PIN): begin
          busRdata[PIN_MOSI]              = pinMosiReg;
          busRdata[PIN_SCK]               = pinSckReg;
          busRdata[PIN_CS_LO +: NUM_CS]   = pinCsReg;
        end
        ADDR_W'(OFS_TX):  busRdata = txReg;
        ADDR_W'(OFS_SC): begin
          busRdata[SC_START]            = busyReg;
          busRdata[SC_CS_LO +: NUM_CS]  = csSelReg;
          busRdata[SC_TERM]             = termReg;
          busRdata[CNT_W-1:0]           = cntField;
        end
        ADDR_W'(OFS_RX):  busRdata = rxData;
        default:          busRdata = '0;
      endcase
    end
  end

  assign busy      = busyReg;
  assign loadCount = effCount;
  assign txData    = txReg;
  assign pinCs     = pinCsReg;
  assign pinSck    = pinSckReg;
  assign pinMosi   = pinMosiReg;
  assign activeCs  = activeCsReg;

  // R11: shift-control writes while busy leave the fields untouched
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busyReg && wrAny && busAddr == ADDR_W'(OFS_SC)) |=>
      ($stable(csSelReg) && $stable(cntField) && $stable(termReg)));

  // R3: busy only ends on the falling edge of the final bit
  assert_busy_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyReg) |-> ($past(bitsLeft) == CNT_W'(1) && $past(phaseHigh)));

  // R5: the held chip select changes only when a transfer starts or ends
  assert_cs_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busyReg && !start) |=> $stable(activeCsReg));

  // R7: rising and falling SCK strobes alternate
  assert_half_period_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rise |=> !strobe.rise);
endmodule

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CS = 3,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strobe,
  input  logic              busy,
  input  logic [DATA_W-1:0] txData,
  input  logic [CNT_W-1:0]  loadCount,
  input  logic              miso,
  input  logic [NUM_CS-1:0] pinCs,
  input  logic              pinSck,
  input  logic              pinMosi,
  input  logic [NUM_CS-1:0] activeCs,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txSh, rxSh;
  logic              sckQ;
  logic [CNT_W-1:0]  shiftAmt;

  // Align the used bits so the first one sits at the MSB
  assign shiftAmt = CNT_W'(DATA_W) - loadCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      rxSh <= '0;
      sckQ <= 1'b0;
    end else if (strobe.load) begin
      txSh <= txData << shiftAmt;
      rxSh <= '0;
      sckQ <= 1'b0;
    end else if (strobe.rise) begin
      sckQ <= 1'b1;
      rxSh <= {rxSh[DATA_W-2:0], miso};
    end else if (strobe.fall) begin
      sckQ <= 1'b0;
      txSh <= {txSh[DATA_W-2:0], 1'b0};
    end
  end

  assign sck    = busy ? sckQ : pinSck;
  assign mosi   = busy ? txSh[DATA_W-1] : pinMosi;
  assign csN    = pinCs & ~activeCs;
  assign rxData = rxSh;

  // R9: the engine's SCK is low whenever it is idle
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckQ);

  // R9: the outgoing bit holds while SCK is high
  assert_mosi_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sckQ && !strobe.fall) |=> $stable(txSh));
endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
  import spi_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_CS = 3,
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN
);
  localparam int CNT_W = $clog2(DATA_W) + 1;

  shiftStrobe_t      strobe;
  logic              busy, pinSck, pinMosi;
  logic [CNT_W-1:0]  loadCount;
  logic [DATA_W-1:0] txData, rxData;
  logic [NUM_CS-1:0] pinCs, activeCs;

  spi_shift_ctrl #(
    .DATA_W(DATA_W), .NUM_CS(NUM_CS), .DIV_W(DIV_W), .ADDR_W(ADDR_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .rxData(rxData), .strobe(strobe), .busy(busy),
    .loadCount(loadCount), .txData(txData),
    .pinCs(pinCs), .pinSck(pinSck), .pinMosi(pinMosi),
    .activeCs(activeCs)
  );

  spi_shift_dp #(
    .DATA_W(DATA_W), .NUM_CS(NUM_CS)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .busy(busy),
    .txData(txData), .loadCount(loadCount), .miso(miso),
    .pinCs(pinCs), .pinSck(pinSck), .pinMosi(pinMosi),
    .activeCs(activeCs),
    .sck(sck), .mosi(mosi), .csN(csN), .rxData(rxData)
  );
endmodule

// File: tb/test_spi_shift_host.sv
module test_spi_shift_host;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        miso;
  logic        sck, mosi;
  logic [2:0]  csN;

  int checks = 0;
  int errors = 0;

  // Device model
  logic        monOn = 1'b0;
  logic [31:0] slaveSh = '0;
  logic [31:0] mosiCap = '0;
  int          riseCnt = 0;

  spi_shift_host i_spi_shift_host (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .miso(miso), .sck(sck), .mosi(mosi), .csN(csN)
  );

  always #4 clk = ~clk;

  assign miso = slaveSh[31];
  always @(posedge sck) if (monOn) begin
    mosiCap = {mosiCap[30:0], mosi};
    riseCnt = riseCnt + 1;
  end
  always @(negedge sck) if (monOn) slaveSh = {slaveSh[30:0], 1'b0};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic busWr(input logic [4:0] addr, input logic [31:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1;
    data = busRdata;
  endtask

  // Runs one transfer and checks timing, pins and data
  task automatic runXfer(input int cs, input bit term, input int cnt, input int div,
                         input logic [31:0] tx, input logic [31:0] sl,
                         input bit inject, input logic [2:0] csAfter);
    int n;
    int t;
    logic [31:0] rd;
    logic [63:0] mask;
    n = (cnt == 0 || cnt > 32) ? 32 : cnt;
    t = 2 * n * (div + 1);
    mask = (64'd1 << n) - 64'd1;
    busWr(5'h04, 32'(div));
    busWr(5'h10, tx);
    slaveSh = sl; mosiCap = '0; riseCnt = 0; monOn = 1'b1;
    busWr(5'h14, (32'd1 << 31) | (32'd1 << (28 + cs)) | (32'(term) << 26) | 32'(cnt));
    for (int k = 1; k < t; k++) begin
      @(negedge clk);
      if (inject && k == 2) begin
        busSel = 1'b1; busWrite = 1'b1; busAddr = 5'h14;
        busWdata = (32'd1 << 31) | (32'd1 << 28) | 32'd3;
      end
      if (inject && k == 3) begin
        busSel = 1'b0; busWrite = 1'b0;
      end
      if (k == t / 2)
        chk("R4 csN mid-transfer", 32'(csN), 32'(3'b111 & ~(3'b001 << cs) & (csAfter | ~(3'b001 << cs))));
    end
    busRd(5'h14, rd);
    chk("R3 busy one cycle before end", 32'(rd[31]), 32'd1);
    @(negedge clk);
    busRd(5'h14, rd);
    chk("R3 busy clear at end", 32'(rd[31]), 32'd0);
    if (inject) chk("R11 count field unchanged", rd & 32'h3F, 32'(cnt));
    chk("R7 rising edge count", 32'(riseCnt), 32'(n));
    chk("R6 MOSI bits MSB first", mosiCap & mask[31:0], tx & mask[31:0]);
    busRd(5'h18, rd);
    chk("R8 received data", rd, 32'(64'(sl) >> (32 - n)));
    chk("R5 csN after transfer", 32'(csN), 32'(csAfter));
    chk("R9 sck idle low", 32'(sck), 32'd0);
    monOn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] rd;
    chk("R1 csN reset", 32'(csN), 32'h7);
    chk("R1 sck reset", 32'(sck), 32'd0);
    chk("R1 mosi reset", 32'(mosi), 32'd0);
    busRd(5'h00, rd);
    chk("R1 enable reads 0", rd, 32'd0);
  endtask

  task automatic testDisabled();
    logic [31:0] rd;
    busWr(5'h04, 32'd5);
    busWr(5'h08, 32'h0);
    busWr(5'h14, 32'h9000_0008);
    repeat (4) @(negedge clk);
    chk("R2 pins untouched while disabled", {27'd0, csN, sck, mosi}, 32'h1C);
    busRd(5'h04, rd);
    chk("R2 reads 0 while disabled", rd, 32'd0);
    busWr(5'h00, 32'd1);
    busRd(5'h04, rd);
    chk("R2 divisor write was ignored", rd, 32'd0);
    busRd(5'h08, rd);
    chk("R1 pin override default", rd, 32'h0007_0000);
  endtask

  task automatic testPinOverride();
    busWr(5'h08, 32'h0005_0101);
    chk("R10 override csN", 32'(csN), 32'h5);
    chk("R10 override sck", 32'(sck), 32'd1);
    chk("R10 override mosi", 32'(mosi), 32'd1);
    busWr(5'h08, 32'h0007_0000);
    chk("R10 override restored", {27'd0, csN, sck, mosi}, 32'h1C);
  endtask

  task automatic testSingleByte();
    runXfer(0, 1'b1, 8, 0, 32'h0000_00A5, 32'h3C00_0000, 1'b0, 3'b111);
  endtask

  task automatic testHeldSelect();
    runXfer(2, 1'b0, 12, 2, 32'h0000_0ABC, 32'h5A30_0000, 1'b0, 3'b011);
    runXfer(2, 1'b1, 4, 0, 32'h0000_0009, 32'hC000_0000, 1'b0, 3'b111);
  endtask

  task automatic testFullWord();
    runXfer(1, 1'b1, 0, 1, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, 3'b111);
  endtask

  task automatic testBusyWrite();
    runXfer(1, 1'b1, 16, 1, 32'h0000_C3E1, 32'h8001_0000, 1'b1, 3'b111);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testPinOverride();
    testSingleByte();
    testHeldSelect();
    testFullWord();
    testBusyWrite();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end
endmodule